// File: doc/BRIEF.md
# Lockstep Multi-String Addressable-LED Transmitter

This block drives several strings of single-wire, one-bit-per-slot addressable RGB LEDs in parallel, with one output line per string. A host fills a bit-plane frame buffer through a pixel write port. Each write carries a lane index, an LED index and a 24-bit colour value. The host then pulses a start input. One shared timing engine walks the buffer one word per bit slot. Each word holds one bit per lane, so every enabled string receives its pulse train in exact lockstep.

Each bit slot is split into three phases. At slot start every enabled line rises. At the first threshold the lines carrying a 0 fall. At the second threshold every line is low, and it stays low until the next slot. Blank slots are placed before and after the data, and all lines are low during them. After the trailing blank, all lines are held low for a reset guard interval. Only then is frame-done raised again.

Top module: `ws_lanes_tx`

## Requirements
- R1: After reset every lane output is low and `frameDone` is 1.
- R2: Inside a data slot, every enabled lane rises in the slot's first cycle. Successive rises are exactly `SLOT_CLKS` clocks apart, and no lane rises while another lane is still high.
- R3: Inside a data slot, a lane whose bit is 0 stays high for `ZERO_FALL` clocks, and a lane whose bit is 1 stays high for `ONE_FALL` clocks (12 and 31 at the defaults). The lane is then low for the rest of the slot.
- R4: Data slots are sent in buffer order: LED 0 first, then each following LED. Each LED uses 24 slots taken from `pixGrb` bit 23 down to bit 0. Green sits in `pixGrb[23:16]`, red in `[15:8]` and blue in `[7:0]`, so each byte goes out most significant bit first.
- R5: A pixel write changes only the addressed lane's bit in the 24 words of the addressed LED. The bits of every other lane are unchanged.
- R6: A lane whose `laneEnable` bit was 0 in the previous cycle is low.
- R7: `LEAD_SLOTS` blank slots are sent before the data and `TRAIL_SLOTS` after it, with every lane low for their whole duration.
- R8: `frameDone` is 0 from the cycle after an accepted start. It rises exactly `GUARD_CLKS` clocks after the trailing blank slots end, so every line has been low for at least `GUARD_CLKS` clocks when it rises. While `frameDone` is 1 all lanes are low.
- R9: A start pulse is accepted only while `frameDone` is 1. A pulse during a frame does not disturb its timing, and `frameDone` only falls after a start pulse.
- R10: Pixel writes presented while `frameDone` is 0 are ignored and leave the buffer unchanged.
- R11: After reset the buffer holds all zeros, so a frame sent before any write carries only 0 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (48 MHz at the default timing) |
| rstN | input | 1 | Asynchronous active-low reset |
| startPulse | input | 1 | Starts a frame when `frameDone` is 1 |
| laneEnable | input | NUM_LANES | Per-lane enable mask |
| pixWrEn | input | 1 | Pixel write strobe |
| pixLane | input | $clog2(NUM_LANES) | Lane addressed by the write |
| pixLed | input | $clog2(MAX_LEDS) | LED position addressed by the write |
| pixGrb | input | 24 | Colour: green [23:16], red [15:8], blue [7:0] |
| frameDone | output | 1 | 1 when idle and the guard interval has elapsed |
| laneOut | output | NUM_LANES | One serial line per string |

## Verification
The bench builds the block with 4 lanes, 2 LEDs per lane, a 20-clock slot with the falls at clocks 4 and 10, a 50-clock guard and one blank slot on each side. A whole frame then lasts about a thousand cycles. This puts every lane bit of every buffer word, both frame edges, the guard interval and the done rise inside a few short frames, and each cycle of each frame is compared with a behavioural model. The short guard and slot keep the same ordering of thresholds as the defaults, so the three-phase timing and the guard-before-done relation are exercised unchanged.

// File: rtl/ws_lanes_pkg.sv
package ws_lanes_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SEND,
    ST_GUARD
  } txState_e;

  // strobes passed from the sequencer to the datapath
  typedef struct packed {
    logic riseAll;    // first cycle of a data slot
    logic dropZeros;  // first threshold reached in a data slot
    logic dropAll;    // second threshold reached in a data slot
    logic wrAllow;    // buffer may be written (engine idle)
  } laneStrobe_t;

endpackage

// File: rtl/ws_lanes_ctrl.sv
module ws_lanes_ctrl
  import ws_lanes_pkg::*;
#(
  parameter int SLOT_CLKS   = 60,
  parameter int ZERO_FALL   = 12,
  parameter int ONE_FALL    = 31,
  parameter int GUARD_CLKS  = 2640,
  parameter int LEAD_SLOTS  = 1,
  parameter int DATA_SLOTS  = 960,
  parameter int TRAIL_SLOTS = 1,
  parameter int ADDR_W      = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startPulse,
  output laneStrobe_t       strb,
  output logic [ADDR_W-1:0] wordAddr,
  output logic              frameDone
);

  localparam int TOTAL_SLOTS = LEAD_SLOTS + DATA_SLOTS + TRAIL_SLOTS;
  localparam int PH_W = $clog2(SLOT_CLKS);
  localparam int SL_W = $clog2(TOTAL_SLOTS + 1);
  localparam int GD_W = $clog2(GUARD_CLKS + 1);

  txState_e          state;
  logic [PH_W-1:0]   phase;
  logic [SL_W-1:0]   slotIdx;
  logic [GD_W-1:0]   guardCnt;
  logic              inData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      phase    <= '0;
      slotIdx  <= '0;
      guardCnt <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (startPulse) begin
            state   <= ST_SEND;
            phase   <= '0;
            slotIdx <= '0;
          end
        end
        ST_SEND: begin
          if (phase == PH_W'(SLOT_CLKS - 1)) begin
            phase <= '0;
            if (slotIdx == SL_W'(TOTAL_SLOTS - 1)) begin
              state    <= ST_GUARD;
              guardCnt <= '0;
            end else begin
              slotIdx <= slotIdx + 1'b1;
            end
          end else begin
            phase <= phase + 1'b1;
          end
        end
        ST_GUARD: begin
          if (guardCnt == GD_W'(GUARD_CLKS - 1)) state <= ST_IDLE;
          else guardCnt <= guardCnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign inData = (state == ST_SEND)
               && (int'(slotIdx) >= LEAD_SLOTS)
               && (int'(slotIdx) < LEAD_SLOTS + DATA_SLOTS);

  assign wordAddr = ADDR_W'(int'(slotIdx) - LEAD_SLOTS);

  always_comb begin
    strb.riseAll   = inData && (phase == '0);
    strb.dropZeros = inData && (phase == PH_W'(ZERO_FALL));
    strb.dropAll   = inData && (phase == PH_W'(ONE_FALL));
    strb.wrAllow   = (state == ST_IDLE);
  end

  assign frameDone = (state == ST_IDLE);

endmodule

// File: rtl/ws_lanes_data.sv
module ws_lanes_data
  import ws_lanes_pkg::*;
#(
  parameter int NUM_LANES    = 32,
  parameter int MAX_LEDS     = 40,
  parameter int BITS_PER_LED = 24,
  parameter int ADDR_W       = 10,
  parameter int LANE_W       = 5,
  parameter int LED_W        = 6
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  laneStrobe_t             strb,
  input  logic [ADDR_W-1:0]       wordAddr,
  input  logic [NUM_LANES-1:0]    laneEnable,
  input  logic                    pixWrEn,
  input  logic [LANE_W-1:0]       pixLane,
  input  logic [LED_W-1:0]        pixLed,
  input  logic [BITS_PER_LED-1:0] pixGrb,
  output logic [NUM_LANES-1:0]    laneOut
);

  localparam int DEPTH = MAX_LEDS * BITS_PER_LED;

  logic [NUM_LANES-1:0] planeMem [DEPTH];
  logic [NUM_LANES-1:0] planeWord;
  logic                 wrHit;

  assign wrHit = strb.wrAllow && pixWrEn && (int'(pixLed) < MAX_LEDS);

  // bit-plane buffer: a write touches one lane column across one LED's words
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int d = 0; d < DEPTH; d++) planeMem[d] <= '0;
    end else if (wrHit) begin
      for (int k = 0; k < BITS_PER_LED; k++)
        planeMem[ADDR_W'(int'(pixLed) * BITS_PER_LED + k)][pixLane]
          <= pixGrb[BITS_PER_LED-1-k];
    end
  end

  assign planeWord = planeMem[wordAddr];

  // one waveform flop per lane, all sharing the sequencer strobes
  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    logic lineQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                lineQ <= 1'b0;
      else if (!laneEnable[l])                  lineQ <= 1'b0;
      else if (strb.riseAll)                    lineQ <= 1'b1;
      else if (strb.dropAll)                    lineQ <= 1'b0;
      else if (strb.dropZeros && !planeWord[l]) lineQ <= 1'b0;
    end
    assign laneOut[l] = lineQ;
  end

endmodule

// File: rtl/ws_lanes_tx.sv
module ws_lanes_tx
  import ws_lanes_pkg::*;
#(
  parameter int NUM_LANES   = 32,
  parameter int MAX_LEDS    = 40,
  parameter int SLOT_CLKS   = 60,
  parameter int ZERO_FALL   = 12,
  parameter int ONE_FALL    = 31,
  parameter int GUARD_CLKS  = 2640,
  parameter int LEAD_SLOTS  = 1,
  parameter int TRAIL_SLOTS = 1
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         startPulse,
  input  logic [NUM_LANES-1:0]         laneEnable,
  input  logic                         pixWrEn,
  input  logic [$clog2(NUM_LANES)-1:0] pixLane,
  input  logic [$clog2(MAX_LEDS)-1:0]  pixLed,
  input  logic [23:0]                  pixGrb,
  output logic                         frameDone,
  output logic [NUM_LANES-1:0]         laneOut
);

  localparam int BITS_PER_LED = 24;
  localparam int DATA_SLOTS   = MAX_LEDS * BITS_PER_LED;
  localparam int ADDR_W       = $clog2(DATA_SLOTS);
  localparam int LANE_W       = $clog2(NUM_LANES);
  localparam int LED_W        = $clog2(MAX_LEDS);

  laneStrobe_t       strb;
  logic [ADDR_W-1:0] wordAddr;

  ws_lanes_ctrl #(
    .SLOT_CLKS  (SLOT_CLKS),
    .ZERO_FALL  (ZERO_FALL),
    .ONE_FALL   (ONE_FALL),
    .GUARD_CLKS (GUARD_CLKS),
    .LEAD_SLOTS (LEAD_SLOTS),
    .DATA_SLOTS (DATA_SLOTS),
    .TRAIL_SLOTS(TRAIL_SLOTS),
    .ADDR_W     (ADDR_W)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .startPulse(startPulse),
    .strb      (strb),
    .wordAddr  (wordAddr),
    .frameDone (frameDone)
  );

  ws_lanes_data #(
    .NUM_LANES   (NUM_LANES),
    .MAX_LEDS    (MAX_LEDS),
    .BITS_PER_LED(BITS_PER_LED),
    .ADDR_W      (ADDR_W),
    .LANE_W      (LANE_W),
    .LED_W       (LED_W)
  ) u_data (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .wordAddr  (wordAddr),
    .laneEnable(laneEnable),
    .pixWrEn   (pixWrEn),
    .pixLane   (pixLane),
    .pixLed    (pixLed),
    .pixGrb    (pixGrb),
    .laneOut   (laneOut)
  );

endmodule

// File: rtl/ws_lanes_tx_chk.sv
module ws_lanes_tx_chk #(
  parameter int NUM_LANES  = 32,
  parameter int ONE_FALL   = 31,
  parameter int GUARD_CLKS = 2640
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 startPulse,
  input logic [NUM_LANES-1:0] laneEnable,
  input logic [NUM_LANES-1:0] laneOut,
  input logic                 frameDone
);

  int highRun;
  int lowRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      highRun <= 0;
      lowRun  <= 0;
    end else begin
      highRun <= (laneOut != '0) ? highRun + 1 : 0;
      if (laneOut != '0)               lowRun <= 0;
      else if (lowRun <= GUARD_CLKS)   lowRun <= lowRun + 1;
    end
  end

  // R6: a lane disabled in the previous cycle is low
  p_mask_r6: assert property (@(posedge clk) disable iff (!rstN)
    (laneOut & ~$past(laneEnable)) == '0);

  // R2: rises happen together, onto the enabled set, only from all-low
  p_rise_r2: assert property (@(posedge clk) disable iff (!rstN)
    ((laneOut & ~$past(laneOut)) != '0) |->
      ($past(laneOut) == '0 && laneOut == $past(laneEnable)));

  // R3: no high phase outlasts the longer threshold
  p_high_r3: assert property (@(posedge clk) disable iff (!rstN)
    highRun <= ONE_FALL);

  // R8: done implies idle lines
  p_done_low_r8: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |-> (laneOut == '0));

  // R8: done rises only after a full guard of low lines
  p_guard_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(frameDone) |-> (lowRun >= GUARD_CLKS));

  // R9: done falls only in response to a start
  p_start_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(frameDone) |-> $past(startPulse));

endmodule

bind ws_lanes_tx ws_lanes_tx_chk #(
  .NUM_LANES (NUM_LANES),
  .ONE_FALL  (ONE_FALL),
  .GUARD_CLKS(GUARD_CLKS)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .startPulse(startPulse),
  .laneEnable(laneEnable),
  .laneOut   (laneOut),
  .frameDone (frameDone)
);

// File: tb/ws_lanes_tx_tb.sv
`timescale 1ns/1ps
module ws_lanes_tx_tb;

  localparam int LANES = 4;
  localparam int LEDS  = 2;
  localparam int SLOT  = 20;
  localparam int ZF    = 4;
  localparam int OF    = 10;
  localparam int GRD   = 50;
  localparam int LEAD  = 1;
  localparam int TRAIL = 1;
  localparam int DATA  = LEDS * 24;
  localparam int TOTAL = LEAD + DATA + TRAIL;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             startPulse = 1'b0;
  logic [LANES-1:0] laneEnable = '0;
  logic             pixWrEn = 1'b0;
  logic [1:0]       pixLane = '0;
  logic [0:0]       pixLed = '0;
  logic [23:0]      pixGrb = '0;
  logic             frameDone;
  logic [LANES-1:0] laneOut;

  int checks = 0;
  int errors = 0;
  logic [23:0] model [LANES][LEDS];

  always #2.5 clk = ~clk;

  ws_lanes_tx #(
    .NUM_LANES(LANES), .MAX_LEDS(LEDS), .SLOT_CLKS(SLOT), .ZERO_FALL(ZF),
    .ONE_FALL(OF), .GUARD_CLKS(GRD), .LEAD_SLOTS(LEAD), .TRAIL_SLOTS(TRAIL)
  ) u_dut (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .laneEnable(laneEnable),
    .pixWrEn(pixWrEn), .pixLane(pixLane), .pixLed(pixLed), .pixGrb(pixGrb),
    .frameDone(frameDone), .laneOut(laneOut)
  );

  function automatic logic [LANES-1:0] expLanes(int k, logic [LANES-1:0] en);
    logic [LANES-1:0] r = '0;
    int c, s, p, w, led, b;
    if (k < 1 || k > TOTAL * SLOT) return '0;
    c = k - 1; s = c / SLOT; p = c % SLOT;
    if (s < LEAD || s >= LEAD + DATA) return '0;
    w = s - LEAD; led = w / 24; b = 23 - (w % 24);
    for (int l = 0; l < LANES; l++)
      r[l] = en[l] && (p < ZF || (p < OF && model[l][led][b]));
    return r;
  endfunction

  function automatic string regionTag(int k, string dataTag);
    int s;
    if (k >= TOTAL * SLOT) return "R8";
    if (k < 1) return "R8";
    s = (k - 1) / SLOT;
    if (s < LEAD || s >= LEAD + DATA) return "R7";
    return dataTag;
  endfunction

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic writePix(int lane, int led, logic [23:0] grb, bit busy);
    pixLane = 2'(lane); pixLed = 1'(led); pixGrb = grb; pixWrEn = 1'b1;
    if (!busy) model[lane][led] = grb;
    @(negedge clk);
    pixWrEn = 1'b0;
  endtask

  // runs one frame and compares outputs against the model after every edge
  task automatic runFrame(logic [LANES-1:0] en, bit intrude, string dataTag);
    logic [LANES-1:0] e;
    laneEnable = en;
    startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    chk(frameDone == 1'b0, "R8", "done after start", int'(frameDone), 0);
    for (int k = 1; k <= TOTAL * SLOT + GRD + 3; k++) begin
      if (intrude && k == 100) begin
        pixLane = 2'd3; pixLed = 1'd0; pixGrb = 24'hFFFFFF; pixWrEn = 1'b1;  // R10
      end
      if (intrude && k == 101) pixWrEn = 1'b0;
      if (intrude && k == 200) startPulse = 1'b1;                           // R9
      if (intrude && k == 201) startPulse = 1'b0;
      @(negedge clk);
      e = expLanes(k, en);
      chk(laneOut == e, regionTag(k, dataTag), $sformatf("lanes k=%0d", k),
          int'(laneOut), int'(e));
      chk(frameDone == (k >= TOTAL * SLOT + GRD), intrude ? "R8/R9" : "R8",
          $sformatf("done k=%0d", k), int'(frameDone),
          int'(k >= TOTAL * SLOT + GRD));
    end
  endtask

  initial begin
    for (int l = 0; l < LANES; l++)
      for (int d = 0; d < LEDS; d++) model[l][d] = '0;
    repeat (3) @(negedge clk);
    chk(laneOut == '0, "R1", "lanes in reset", int'(laneOut), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(laneOut == '0, "R1", "lanes after reset", int'(laneOut), 0);
    chk(frameDone == 1'b1, "R1", "done after reset", int'(frameDone), 1);

    // R11: empty buffer gives only short pulses; also R2/R3 timing
    runFrame(4'b1111, 1'b0, "R11/R3");

    // R4: distinct colours, bit order and LED order
    writePix(0, 0, 24'hA5C3F0, 1'b0);
    writePix(0, 1, 24'h0F0F0F, 1'b0);
    writePix(1, 0, 24'hFFFFFF, 1'b0);
    writePix(1, 1, 24'h800001, 1'b0);
    writePix(2, 1, 24'h123456, 1'b0);
    writePix(3, 0, 24'hFEDCBA, 1'b0);
    writePix(3, 1, 24'h555555, 1'b0);
    runFrame(4'b1111, 1'b0, "R4/R2");

    // R5: rewrite one lane, neighbours keep their bits
    writePix(1, 0, 24'h00FF00, 1'b0);
    runFrame(4'b1111, 1'b0, "R5");

    // R6 with a partial mask; R9 and R10 stimulus while busy
    runFrame(4'b0101, 1'b1, "R6");

    // R10: the write made while busy must not appear
    runFrame(4'b1111, 1'b0, "R10");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule